// File: doc/BRIEF.md
# Reset Interrupt Detection Sequencer

This block turns the release of an active-low reset pin into the reset interrupt of a pipelined processor. The raw pin is brought into the clock domain through a chain of flip-flops. A saturating counter then measures how long the pin stays low, so that only a low period of the required length counts as a reset. When the pin goes high after such a period, a release delay counts a fixed number of clocks. This delay runs on every clock and does not pause for memory stalls.

When the delay has run out, the block waits for the next processor-cycle boundary that is not stalled. On that boundary it sets the reset flag, which is bit 0 of the interrupt flag register, and sends a one-clock pulse that starts the fetch of the reset service packet. It then blocks non-reset interrupts for a fixed number of processor cycles. The pipeline-flush enable is high while the pin is low and the sequencer is idle. The acknowledge output, the interrupt number and both interrupt enables stay 0, because nothing in the reset sequence raises them. If the pin goes low again before the sequence has finished, the sequence is abandoned and the low time has to qualify again.

Top module: `rst_irq_seq`

## Requirements
- R1: A reset is accepted only when the synchronized pin has been low for at least LOW_MIN (10) consecutive clocks. A low period of 9 clocks, after power-up or after a previous sequence, never sets the flag and never pulses fetch_start.
- R2: While reset_irq_n (rst_ni) is low, rst_flag, fetch_start and irq_block are 0 and flush_en is 1.
- R3: Take edge k as the first rising clock edge that samples the pin high after a qualified low period. With cpu_bnd high and mem_stall low on every clock, rst_flag is 0 after edge k+5 and 1 after edge k+6. This delay is two synchronizer stages plus a four-clock release delay.
- R4: mem_stall does not stretch the four-clock release delay. However, a cpu_bnd that coincides with mem_stall is not a boundary, for setting the flag or for counting the blocking window.
- R5: If no valid boundary arrives when the release delay ends, rst_flag stays 0 until the first clock edge that samples cpu_bnd=1 with mem_stall=0.
- R6: fetch_start is a pulse exactly one clock long. It is issued on the same edge on which rst_flag goes from 0 to 1, and once per reset sequence.
- R7: flush_en is 1 while the sequencer is idle and the synchronized pin is low. It is 0 from the clock after the synchronized pin goes high, and whenever rst_flag is 1.
- R8: irq_block goes to 1 on the edge that sets rst_flag. It goes back to 0 on the edge of the seventh valid boundary after that edge.
- R9: nmie, gie, iack and inum are 0 at all times.
- R10: If the pin goes low during the release delay, while waiting for the boundary, or during the blocking window, then rst_flag and irq_block drop to 0 and flush_en goes to 1. A new sequence starts only after a fresh qualified low period.
- R11: Once the blocking window has ended, a low pulse shorter than LOW_MIN clocks is ignored. rst_flag stays 1, flush_en stays 0 and no fetch_start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer logic |
| reset_pin_n | input | 1 | Raw active-low reset pin, asynchronous to clk |
| cpu_bnd | input | 1 | Strobe marking the last clock of a processor cycle |
| mem_stall | input | 1 | Memory stall stretching the current processor cycle |
| rst_flag | output | 1 | Bit 0 of the interrupt flag register (reset flag) |
| flush_en | output | 1 | Pipeline flush enable |
| fetch_start | output | 1 | One-clock pulse starting the reset packet fetch |
| nmie | output | 1 | Non-maskable interrupt enable (held 0) |
| gie | output | 1 | Global maskable interrupt enable (held 0) |
| irq_block | output | 1 | Blocks non-reset interrupt processing |
| iack | output | 1 | Interrupt acknowledge (held 0) |
| inum | output | IRQ_NUM_W | Interrupt number (held 0) |

## Verification
The assertions assume that cpu_bnd and mem_stall are synchronous to clk. They treat a boundary as one clock in which cpu_bnd is high and mem_stall is low. The pin is the only input allowed to be asynchronous, and the properties look only at its synchronized copy. The stimulus changes every input on the falling clock edge. Each low period on the pin is held for whole clocks, so that the low-time count and the edge on which the flag rises can be predicted exactly from the number of clocks driven.

// File: rtl/rst_irq_pkg.sv
package rst_irq_pkg;

  // Sequencer phases, from idle through the post-flag blocking window.
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_DELAY = 3'd1,
    SQ_ARM   = 3'd2,
    SQ_BLOCK = 3'd3,
    SQ_RUN   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin_n,
  output logic pin_s
);

  logic [STAGES-1:0] q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) q[g] <= 1'b0;
          else         q[g] <= pin_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) q[g] <= 1'b0;
          else         q[g] <= q[g-1];
        end
      end
    end
  endgenerate

  assign pin_s = q[STAGES-1];

endmodule

// File: rtl/rst_low_qual.sv
module rst_low_qual #(
  parameter int LOW_MIN = 10
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin_s,
  output logic qual,
  output logic low_done
);

  localparam int CW = $clog2(LOW_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(LOW_MIN);
  localparam logic [CW-1:0] CPRE = CW'(LOW_MIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Counter advances while low until it saturates; any high sample clears it.
  always_comb begin
    cnt_en = pin_s || (cnt_q != CMAX);
    cnt_d  = pin_s ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual     = pin_s && (cnt_q == CMAX);
  assign low_done = !pin_s && (cnt_q == CPRE);

  AST_LOW_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CMAX);  // R1
  AST_QUAL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    qual |-> $past(!pin_s));  // R1
  AST_QUAL_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_ni)
    qual |=> !qual);  // R1

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_irq_pkg::*;
#(
  parameter int REL_DLY = 4,
  parameter int BLK_CYC = 7
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin_s,
  input  logic qual,
  input  logic low_done,
  input  logic cpu_bnd,
  input  logic mem_stall,
  output logic rst_flag,
  output logic fetch_start,
  output logic irq_block,
  output logic flush_en
);

  localparam int DW = $clog2(REL_DLY + 1);
  localparam int BW = $clog2(BLK_CYC + 1);
  localparam logic [DW-1:0] DLAST = DW'(REL_DLY - 1);
  localparam logic [BW-1:0] BLAST = BW'(BLK_CYC - 1);

  seq_state_e    st_q, st_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          flag_q, flag_d;
  logic          fetch_q, fetch_d;
  logic          dcnt_en, bcnt_en;
  logic          bnd_ok;

  assign bnd_ok = cpu_bnd && !mem_stall;

  always_comb begin
    st_d    = st_q;
    dcnt_d  = dcnt_q;
    bcnt_d  = bcnt_q;
    flag_d  = flag_q;
    fetch_d = 1'b0;
    dcnt_en = 1'b0;
    bcnt_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        flag_d = 1'b0;
        if (qual) begin
          st_d    = SQ_DELAY;
          dcnt_d  = DW'(1);
          dcnt_en = 1'b1;
        end
      end
      SQ_DELAY: begin
        if (!pin_s) begin
          st_d   = SQ_IDLE;
          flag_d = 1'b0;
        end else if (dcnt_q >= DLAST) begin
          st_d = SQ_ARM;
        end else begin
          dcnt_d  = dcnt_q + 1'b1;
          dcnt_en = 1'b1;
        end
      end
      SQ_ARM: begin
        if (!pin_s) begin
          st_d   = SQ_IDLE;
          flag_d = 1'b0;
        end else if (bnd_ok) begin
          st_d    = SQ_BLOCK;
          flag_d  = 1'b1;
          fetch_d = 1'b1;
          bcnt_d  = '0;
          bcnt_en = 1'b1;
        end
      end
      SQ_BLOCK: begin
        if (!pin_s) begin
          st_d   = SQ_IDLE;
          flag_d = 1'b0;
        end else if (bnd_ok) begin
          if (bcnt_q == BLAST) begin
            st_d = SQ_RUN;
          end else begin
            bcnt_d  = bcnt_q + 1'b1;
            bcnt_en = 1'b1;
          end
        end
      end
      SQ_RUN: begin
        if (low_done) begin
          st_d   = SQ_IDLE;
          flag_d = 1'b0;
        end
      end
      default: begin
        st_d   = SQ_IDLE;
        flag_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      flag_q  <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      flag_q  <= flag_d;
      fetch_q <= fetch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      dcnt_q <= '0;
    else if (dcnt_en) dcnt_q <= dcnt_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      bcnt_q <= '0;
    else if (bcnt_en) bcnt_q <= bcnt_d;
  end

  assign rst_flag    = flag_q;
  assign fetch_start = fetch_q;
  assign irq_block   = (st_q == SQ_BLOCK);
  assign flush_en    = (st_q == SQ_IDLE) && !pin_s;

  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    fetch_start |=> !fetch_start);  // R6
  AST_FLAG_RISE_FETCH: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_flag) |-> fetch_start);  // R6
  AST_FETCH_ON_BND: assert property (@(posedge clk) disable iff (!rst_ni)
    fetch_start |-> $past(cpu_bnd && !mem_stall));  // R4
  AST_DELAY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == SQ_DELAY && pin_s) |=> (st_q == SQ_DELAY || st_q == SQ_ARM));  // R4
  AST_BLOCK_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_block |-> rst_flag);  // R8
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    ((st_q == SQ_DELAY || st_q == SQ_ARM || st_q == SQ_BLOCK) && !pin_s)
      |=> (!rst_flag && !irq_block));  // R10
  AST_NO_FLUSH_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_flag |-> !flush_en);  // R7

endmodule

// File: rtl/rst_irq_seq.sv
module rst_irq_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MIN     = 10,
  parameter int REL_DLY     = 4,
  parameter int BLK_CYC     = 7,
  parameter int IRQ_NUM_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 reset_pin_n,
  input  logic                 cpu_bnd,
  input  logic                 mem_stall,
  output logic                 rst_flag,
  output logic                 flush_en,
  output logic                 fetch_start,
  output logic                 nmie,
  output logic                 gie,
  output logic                 irq_block,
  output logic                 iack,
  output logic [IRQ_NUM_W-1:0] inum
);

  logic pin_s;
  logic qual;
  logic low_done;

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pin_n  (reset_pin_n),
    .pin_s  (pin_s)
  );

  rst_low_qual #(.LOW_MIN(LOW_MIN)) u_qual (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .pin_s    (pin_s),
    .qual     (qual),
    .low_done (low_done)
  );

  rst_seq_fsm #(.REL_DLY(REL_DLY), .BLK_CYC(BLK_CYC)) u_fsm (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .pin_s       (pin_s),
    .qual        (qual),
    .low_done    (low_done),
    .cpu_bnd     (cpu_bnd),
    .mem_stall   (mem_stall),
    .rst_flag    (rst_flag),
    .fetch_start (fetch_start),
    .irq_block   (irq_block),
    .flush_en    (flush_en)
  );

  // The reset sequence never acknowledges or numbers an interrupt,
  // and leaves both interrupt enables cleared.
  assign nmie = 1'b0;
  assign gie  = 1'b0;
  assign iack = 1'b0;
  assign inum = '0;

endmodule

// File: tb/rst_irq_seq_tb.sv
module rst_irq_seq_tb;

  localparam int NW = 4;

  logic          clk;
  logic          rst_ni;
  logic          reset_pin_n;
  logic          cpu_bnd;
  logic          mem_stall;
  logic          rst_flag;
  logic          flush_en;
  logic          fetch_start;
  logic          nmie;
  logic          gie;
  logic          irq_block;
  logic          iack;
  logic [NW-1:0] inum;

  int vectors    = 0;
  int miscompares = 0;
  int fetch_cnt  = 0;
  int const_bad  = 0;
  bit done       = 0;

  rst_irq_seq #(.IRQ_NUM_W(NW)) u_dut (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .reset_pin_n (reset_pin_n),
    .cpu_bnd     (cpu_bnd),
    .mem_stall   (mem_stall),
    .rst_flag    (rst_flag),
    .flush_en    (flush_en),
    .fetch_start (fetch_start),
    .nmie        (nmie),
    .gie         (gie),
    .irq_block   (irq_block),
    .iack        (iack),
    .inum        (inum)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Outputs are observed on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (fetch_start) fetch_cnt++;
    if (nmie || gie || iack || (inum != '0)) const_bad++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive the pin low for n clocks; on return the pin has just gone high,
  // so the next rising edge is edge k.
  task automatic pulse_low(input int n);
    reset_pin_n = 1'b0;
    step(n);
    reset_pin_n = 1'b1;
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0; reset_pin_n = 1'b1; cpu_bnd = 1'b1; mem_stall = 1'b0;
    step(3);
    chk("R2 flag in reset", rst_flag, 0);
    chk("R2 fetch in reset", fetch_start, 0);
    chk("R2 block in reset", irq_block, 0);
    chk("R2 flush in reset", flush_en, 1);
    chk("R9 enables in reset", {nmie, gie, iack}, 0);
    rst_ni = 1'b1;
    step(20);
    chk("R1 no sequence without low pin", rst_flag, 0);
  endtask

  task automatic t_short_boot();
    int f0 = fetch_cnt;
    pulse_low(9);
    step(25);
    chk("R1 9-clock low ignored flag", rst_flag, 0);
    chk("R1 9-clock low ignored fetch", fetch_cnt - f0, 0);
  endtask

  task automatic t_nominal();
    int f0;
    cpu_bnd = 1'b1; mem_stall = 1'b0;
    reset_pin_n = 1'b0;
    step(5);
    chk("R7 flush while low", flush_en, 1);
    step(5);
    reset_pin_n = 1'b1;
    f0 = fetch_cnt;
    step(6);
    chk("R3 flag still 0 at k+5", rst_flag, 0);
    chk("R7 flush off after release", flush_en, 0);
    step(1);
    chk("R3 flag set at k+6", rst_flag, 1);
    chk("R6 fetch with flag", fetch_start, 1);
    chk("R8 block rises with flag", irq_block, 1);
    step(1);
    chk("R6 fetch one clock", fetch_start, 0);
    step(5);
    chk("R8 block through 6th boundary", irq_block, 1);
    step(1);
    chk("R8 block ends at 7th boundary", irq_block, 0);
    chk("R6 one pulse per sequence", fetch_cnt - f0, 1);
    chk("R3 flag held", rst_flag, 1);
  endtask

  task automatic t_glitch_run();
    int f0 = fetch_cnt;
    reset_pin_n = 1'b0;
    step(3);
    chk("R11 no flush on glitch", flush_en, 0);
    step(2);
    reset_pin_n = 1'b1;
    step(20);
    chk("R11 flag kept after glitch", rst_flag, 1);
    chk("R11 no fetch on glitch", fetch_cnt - f0, 0);
    pulse_low(9);
    step(20);
    chk("R1 9-clock low in run ignored", rst_flag, 1);
    chk("R1 9-clock low in run no fetch", fetch_cnt - f0, 0);
  endtask

  task automatic t_stall_delay();
    cpu_bnd = 1'b1; mem_stall = 1'b0;
    pulse_low(10);
    mem_stall = 1'b1;
    step(6);
    chk("R4 flag 0 at k+5 under stall", rst_flag, 0);
    mem_stall = 1'b0;
    step(1);
    chk("R4 stall did not stretch delay", rst_flag, 1);
    mem_stall = 1'b1;
    step(2);
    mem_stall = 1'b0;
    step(6);
    chk("R4 stalled boundaries not counted", irq_block, 1);
    step(1);
    chk("R8 window ends after 7 valid boundaries", irq_block, 0);
  endtask

  task automatic t_late_bnd();
    int f0;
    cpu_bnd = 1'b1; mem_stall = 1'b0;
    pulse_low(10);
    cpu_bnd = 1'b0;
    f0 = fetch_cnt;
    step(10);
    chk("R5 flag waits for boundary", rst_flag, 0);
    cpu_bnd = 1'b1; mem_stall = 1'b1;
    step(1);
    chk("R4 stalled boundary sets no flag", rst_flag, 0);
    mem_stall = 1'b0;
    step(1);
    chk("R5 flag on first valid boundary", rst_flag, 1);
    chk("R5 fetch on first valid boundary", fetch_start, 1);
    step(10);
    chk("R6 single pulse late boundary", fetch_cnt - f0, 1);
  endtask

  task automatic t_abort();
    int f0;
    cpu_bnd = 1'b1; mem_stall = 1'b0;
    pulse_low(10);
    f0 = fetch_cnt;
    step(9);
    chk("R10 in window before abort", irq_block, 1);
    reset_pin_n = 1'b0;
    step(3);
    chk("R10 flag cleared on abort", rst_flag, 0);
    chk("R10 block cleared on abort", irq_block, 0);
    chk("R10 flush on abort", flush_en, 1);
    reset_pin_n = 1'b1;
    step(20);
    chk("R10 short low after abort no flag", rst_flag, 0);
    chk("R10 no new fetch after abort", fetch_cnt - f0, 1);
    pulse_low(10);
    step(7);
    chk("R10 requalified sequence sets flag", rst_flag, 1);
    step(10);
  endtask

  initial begin
    t_reset_state();
    t_short_boot();
    t_nominal();
    t_glitch_run();
    t_stall_delay();
    t_late_bnd();
    t_abort();
    chk("R9 enables and acknowledge stay 0", const_bad, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule